// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one processor for up to 256 vectors. It holds three bit maps: vectors that have been requested, vectors now in service, and vectors that arrived level-triggered. A source raises a request by presenting a vector, a delivery mode and a trigger type for one cycle. The block then reports the best vector it is willing to deliver. The core takes that vector with an acknowledge pulse, which moves it from requested to in service.

An end-of-interrupt pulse retires the highest vector in service. If that vector came in level-triggered, the block emits a one-cycle notification carrying the vector, so an external controller can re-arm the line. A task-priority register and the processor-priority value derived from it are available for reading. The search for the highest set bit in each map is a purely combinational priority encoder over the whole map.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Vector v lives in word v/32, bit v%32 of each map. The offered vector is the highest-numbered requested vector, across word boundaries, from 0 up to 255.
- R2: `ppr_o` equals the 8-bit task priority when the task priority's upper nibble is greater than or equal to the upper nibble of the highest in-service vector. Otherwise it is that vector's upper nibble followed by four zero bits. An empty in-service map counts as vector 0. A task-priority write stores all 8 bits.
- R3: `pend_valid_o` is high only when `enable_i` is high, some vector is requested, and the upper nibble of the highest requested vector is strictly greater than the upper nibble of the highest in-service vector (empty counts as 0). `pend_vec_o` is then that requested vector.
- R4: An acknowledge of vector v sets v in service and clears its requested bit.
- R5: An end-of-interrupt pulse clears the highest in-service vector. If its level bit was set, the level bit is cleared and, in the cycle after the pulse, `eoi_ntf_o` is high for one cycle with `eoi_ntf_vec_o` equal to the vector. With nothing in service, the pulse changes nothing.
- R6: A request is taken only for mode 3'b000 (fixed) or 3'b001 (lowest priority). Other mode codes have no effect. A taken request sets the requested bit, and when `req_level_i` is 1 it also sets the level bit. A level request for a vector already requested is dropped and leaves the level bit unchanged.
- R7: While `enable_i` is low, requests are dropped and leave no trace after re-enabling. Acknowledge and end-of-interrupt still operate.
- R8: Reset clears all three maps and the task priority, so nothing is pending and `ppr_o` reads 0.
- R9: When a request and an acknowledge name the same vector in one cycle, the vector ends up both in service and requested. A level request in that cycle is not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Controller enable |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_mode_i | input | 3 | Delivery mode of the request |
| req_level_i | input | 1 | 1 = level-triggered request |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_i | input | 1 | End-of-interrupt pulse |
| tpr_we_i | input | 1 | Task priority write enable |
| tpr_wdata_i | input | 8 | Task priority write data |
| pend_valid_o | output | 1 | A vector is deliverable |
| pend_vec_o | output | 8 | Deliverable vector |
| ppr_o | output | 8 | Processor priority |
| eoi_ntf_o | output | 1 | One-cycle level end-of-interrupt notification |
| eoi_ntf_vec_o | output | 8 | Vector of the notification |

## Verification
Some properties are checked on every cycle: an offered vector is always enabled and present in the requested map, processor priority never falls below task priority, an acknowledged vector is in service on the next cycle, a notification always follows an end-of-interrupt pulse, and the requested map holds still while disabled without acknowledges. Other behaviours can only be shown by the bench's scenarios. These include nested in-service retirement order, the priority-class gate on delivery, the dropped level re-request, which mode codes are ignored, simultaneous request and acknowledge, and the vector boundaries at 0x1F/0x20/0xFF.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // priority class is the upper nibble of a vector
  localparam int CLS_W = 4;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWEST = 3'b001,
    DM_RSVD2  = 3'b010,
    DM_RSVD3  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_EXT    = 3'b111
  } dmode_e;
endpackage

// File: rtl/irq_prio_find.sv
// Combinational highest-set-bit search: per-word encoders, then word select.
module irq_prio_find #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] map_i,
  output logic               found_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WIDX_W    = VEC_W - BIT_W;

  logic [NUM_WORDS-1:0]       word_any;
  logic [NUM_WORDS*BIT_W-1:0] word_top;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] slice;
    logic [BIT_W-1:0]  top_b;
    assign slice = map_i[g*WORD_W +: WORD_W];
    always_comb begin
      top_b = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (slice[b]) top_b = BIT_W'(b);
      end
    end
    assign word_any[g]                  = |slice;
    assign word_top[g*BIT_W +: BIT_W]   = top_b;
  end

  logic [WIDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) sel = WIDX_W'(w);
    end
  end

  assign found_o = |word_any;
  assign vec_o   = {sel, word_top[sel*BIT_W +: BIT_W]};
endmodule

// File: rtl/irq_prio_map.sv
// One vector bit map held as words; per-word clock enable, clear then set.
module irq_prio_map #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] map_o
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] set_w, clr_w, word_d, word_q;
    logic              word_en;

    assign set_w = set_i[g*WORD_W +: WORD_W];
    assign clr_w = clr_i[g*WORD_W +: WORD_W];

    always_comb begin
      word_en = |(set_w | clr_w);
      word_d  = (word_q & ~clr_w) | set_w;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign map_o[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irq_prio_judge.sv
// Delivery gate and processor priority from the encoder results.
module irq_prio_judge
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             enable_i,
  input  logic             irr_found_i,
  input  logic [VEC_W-1:0] irr_top_i,
  input  logic             isr_found_i,
  input  logic [CLS_W-1:0] isr_cls_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic             pend_valid_o,
  output logic [VEC_W-1:0] pend_vec_o,
  output logic [VEC_W-1:0] ppr_o
);
  logic [CLS_W-1:0] svc_cls, req_cls, tpr_cls;

  always_comb begin
    svc_cls = isr_found_i ? isr_cls_i : '0;
    req_cls = irr_top_i[VEC_W-1 -: CLS_W];
    tpr_cls = tpr_i[VEC_W-1 -: CLS_W];

    pend_valid_o = enable_i && irr_found_i && (req_cls > svc_cls);
    pend_vec_o   = irr_top_i;

    if (tpr_cls >= svc_cls) ppr_o = tpr_i;
    else                    ppr_o = {svc_cls, {(VEC_W-CLS_W){1'b0}}};
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic [2:0]       req_mode_i,
  input  logic             req_level_i,
  input  logic             ack_valid_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  input  logic             eoi_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  output logic             pend_valid_o,
  output logic [VEC_W-1:0] pend_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_ntf_o,
  output logic [VEC_W-1:0] eoi_ntf_vec_o
);
  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // maps and searches
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
  logic               irr_found, isr_found;
  logic [VEC_W-1:0]   irr_top, isr_top;

  irq_prio_map #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst_ni(rst_ni), .set_i(irr_set), .clr_i(irr_clr), .map_o(irr_q));
  irq_prio_map #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst_ni(rst_ni), .set_i(isr_set), .clr_i(isr_clr), .map_o(isr_q));
  irq_prio_map #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .rst_ni(rst_ni), .set_i(tmr_set), .clr_i(tmr_clr), .map_o(tmr_q));

  irq_prio_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_find_irr (
    .map_i(irr_q), .found_o(irr_found), .vec_o(irr_top));
  irq_prio_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_find_isr (
    .map_i(isr_q), .found_o(isr_found), .vec_o(isr_top));

  // task priority register
  logic [VEC_W-1:0] tpr_d, tpr_q;
  always_comb tpr_d = tpr_wdata_i;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       tpr_q <= '0;
    else if (tpr_we_i) tpr_q <= tpr_d;
  end

  // request / acknowledge / end-of-interrupt next-state decode
  logic             mode_ok, same_vec, req_bit_after_ack, req_take;
  logic             eoi_do, eoi_lvl;
  logic [NUM_VEC-1:0] req_mask, ack_mask, eoi_mask;
  logic             ntf_d;
  logic [VEC_W-1:0] ntf_vec_d;

  always_comb begin
    mode_ok  = (dmode_e'(req_mode_i) == DM_FIXED) || (dmode_e'(req_mode_i) == DM_LOWEST);
    req_mask = ONE << req_vec_i;
    ack_mask = ack_valid_i ? (ONE << ack_vec_i) : '0;
    eoi_mask = ONE << isr_top;
    same_vec = ack_valid_i && (ack_vec_i == req_vec_i);
    // the acknowledge of the same cycle counts before the drop test
    req_bit_after_ack = irr_q[req_vec_i] && !same_vec;
    req_take = req_valid_i && enable_i && mode_ok && !(req_level_i && req_bit_after_ack);

    eoi_do  = eoi_i && isr_found;
    eoi_lvl = eoi_do && tmr_q[isr_top];

    irr_set = req_take ? req_mask : '0;
    irr_clr = ack_mask;
    isr_set = ack_mask;
    isr_clr = eoi_do ? eoi_mask : '0;
    tmr_set = (req_take && req_level_i) ? req_mask : '0;
    tmr_clr = eoi_lvl ? eoi_mask : '0;

    ntf_d     = eoi_lvl;
    ntf_vec_d = isr_top;
  end

  // level end-of-interrupt notification
  logic             ntf_q;
  logic [VEC_W-1:0] ntf_vec_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ntf_q     <= 1'b0;
      ntf_vec_q <= '0;
    end else begin
      ntf_q <= ntf_d;
      if (ntf_d) ntf_vec_q <= ntf_vec_d;
    end
  end
  assign eoi_ntf_o     = ntf_q;
  assign eoi_ntf_vec_o = ntf_vec_q;

  irq_prio_judge #(.VEC_W(VEC_W)) u_judge (
    .enable_i    (enable_i),
    .irr_found_i (irr_found),
    .irr_top_i   (irr_top),
    .isr_found_i (isr_found),
    .isr_cls_i   (isr_top[VEC_W-1 -: CLS_W]),
    .tpr_i       (tpr_q),
    .pend_valid_o(pend_valid_o),
    .pend_vec_o  (pend_vec_o),
    .ppr_o       (ppr_o)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               ack_valid_i,
  input logic [VEC_W-1:0]   ack_vec_i,
  input logic               eoi_i,
  input logic               pend_valid_o,
  input logic [VEC_W-1:0]   pend_vec_o,
  input logic [VEC_W-1:0]   ppr_o,
  input logic [VEC_W-1:0]   tpr_q,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic               eoi_ntf_o
);
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_valid_o |-> enable_i); // R3
  AST_PEND_IS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_valid_o |-> irr_q[pend_vec_o]); // R3
  AST_PPR_NOT_BELOW_TPR: assert property (@(posedge clk) disable iff (!rst_ni)
    ppr_o >= tpr_q); // R2
  AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_valid_i |=> isr_q[$past(ack_vec_i)]); // R4
  AST_NTF_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_ni)
    eoi_ntf_o |-> $past(eoi_i)); // R5
  AST_OFF_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    (!enable_i && !ack_valid_i) |=> $stable(irr_q)); // R7
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .enable_i(enable_i), .ack_valid_i(ack_valid_i),
  .ack_vec_i(ack_vec_i), .eoi_i(eoi_i), .pend_valid_o(pend_valid_o),
  .pend_vec_o(pend_vec_o), .ppr_o(ppr_o), .tpr_q(tpr_q), .irr_q(irr_q),
  .isr_q(isr_q), .eoi_ntf_o(eoi_ntf_o));

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b1;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_vec_i = '0;
  logic [2:0] req_mode_i = '0;
  logic       req_level_i = 1'b0;
  logic       ack_valid_i = 1'b0;
  logic [7:0] ack_vec_i = '0;
  logic       eoi_i = 1'b0;
  logic       tpr_we_i = 1'b0;
  logic [7:0] tpr_wdata_i = '0;
  logic       pend_valid_o, eoi_ntf_o;
  logic [7:0] pend_vec_o, ppr_o, eoi_ntf_vec_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .req_valid_i(req_valid_i), .req_vec_i(req_vec_i), .req_mode_i(req_mode_i),
    .req_level_i(req_level_i), .ack_valid_i(ack_valid_i), .ack_vec_i(ack_vec_i),
    .eoi_i(eoi_i), .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
    .pend_valid_o(pend_valid_o), .pend_vec_o(pend_vec_o), .ppr_o(ppr_o),
    .eoi_ntf_o(eoi_ntf_o), .eoi_ntf_vec_o(eoi_ntf_vec_o));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expect a pending vector, or none when vld is 0
  task automatic chk_pend(string tag, logic vld, logic [7:0] vec);
    check({tag, " pend_valid"}, 32'(pend_valid_o), 32'(vld));
    if (vld) check({tag, " pend_vec"}, 32'(pend_vec_o), 32'(vec));
  endtask

  // all drivers move at the falling edge; one posedge per operation
  task automatic do_reset();
    rst_n = 1'b0;
    enable_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_req(logic [7:0] v, logic lvl, logic [2:0] mode);
    req_valid_i = 1'b1; req_vec_i = v; req_level_i = lvl; req_mode_i = mode;
    @(negedge clk);
    req_valid_i = 1'b0; req_level_i = 1'b0; req_mode_i = '0;
  endtask

  task automatic do_ack(logic [7:0] v);
    ack_valid_i = 1'b1; ack_vec_i = v;
    @(negedge clk);
    ack_valid_i = 1'b0;
  endtask

  task automatic do_req_ack(logic [7:0] v, logic lvl);
    req_valid_i = 1'b1; req_vec_i = v; req_level_i = lvl; req_mode_i = 3'b000;
    ack_valid_i = 1'b1; ack_vec_i = v;
    @(negedge clk);
    req_valid_i = 1'b0; req_level_i = 1'b0; ack_valid_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1;
    @(negedge clk);
    eoi_i = 1'b0;
  endtask

  task automatic do_tpr(logic [7:0] val);
    tpr_we_i = 1'b1; tpr_wdata_i = val;
    @(negedge clk);
    tpr_we_i = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_pend("R8 after reset", 1'b0, 8'h00);
    check("R8 ppr after reset", 32'(ppr_o), 32'h00);
    check("R8 no notify after reset", 32'(eoi_ntf_o), 32'h0);
    do_req(8'h90, 1'b0, 3'b000);
    do_tpr(8'h77);
    do_ack(8'hA0);
    do_reset();
    chk_pend("R8 maps cleared", 1'b0, 8'h00);
    check("R8 tpr cleared", 32'(ppr_o), 32'h00);
  endtask

  task automatic t_class_gate();
    do_reset();
    do_req(8'h05, 1'b0, 3'b000);
    chk_pend("R3 class 0 never offered", 1'b0, 8'h00);
    do_req(8'h31, 1'b0, 3'b000);
    chk_pend("R3 offer 0x31", 1'b1, 8'h31);
    do_ack(8'h31);
    chk_pend("R4 acked vector leaves requests", 1'b0, 8'h00);
    check("R2 ppr from in-service class", 32'(ppr_o), 32'h30);
    do_req(8'h38, 1'b0, 3'b000);
    chk_pend("R3 same class blocked", 1'b0, 8'h00);
    do_req(8'h4A, 1'b0, 3'b000);
    chk_pend("R3 higher class offered", 1'b1, 8'h4A);
    do_tpr(8'h52);
    check("R2 tpr dominates", 32'(ppr_o), 32'h52);
    do_tpr(8'h2F);
    check("R2 in-service dominates", 32'(ppr_o), 32'h30);
    do_tpr(8'h3C);
    check("R2 equal class keeps full tpr", 32'(ppr_o), 32'h3C);
    do_eoi();
    check("R5 edge vector gives no notify", 32'(eoi_ntf_o), 32'h0);
    check("R2 ppr after retire", 32'(ppr_o), 32'h3C);
    chk_pend("R3 after retire", 1'b1, 8'h4A);
  endtask

  task automatic t_nested_eoi();
    do_reset();
    do_req(8'h40, 1'b0, 3'b000);
    do_ack(8'h40);
    do_req(8'h90, 1'b1, 3'b000);
    chk_pend("R3 nested offer", 1'b1, 8'h90);
    do_ack(8'h90);
    check("R2 ppr nested", 32'(ppr_o), 32'h90);
    do_eoi();
    check("R5 notify level 0x90", 32'(eoi_ntf_o), 32'h1);
    check("R5 notify vector", 32'(eoi_ntf_vec_o), 32'h90);
    check("R5 highest retired first", 32'(ppr_o), 32'h40);
    @(negedge clk);
    check("R5 notify lasts one cycle", 32'(eoi_ntf_o), 32'h0);
    do_eoi();
    check("R5 edge retire no notify", 32'(eoi_ntf_o), 32'h0);
    check("R5 all retired", 32'(ppr_o), 32'h00);
    do_req(8'h55, 1'b0, 3'b000);
    do_eoi();
    check("R5 empty eoi ignored notify", 32'(eoi_ntf_o), 32'h0);
    chk_pend("R5 empty eoi leaves requests", 1'b1, 8'h55);
  endtask

  task automatic t_level_drop();
    do_reset();
    do_req(8'h70, 1'b0, 3'b000);
    do_req(8'h70, 1'b1, 3'b000);
    do_ack(8'h70);
    do_eoi();
    check("R6 dropped level request sets no level bit", 32'(eoi_ntf_o), 32'h0);
    do_req(8'h71, 1'b1, 3'b001);
    chk_pend("R6 lowest-priority mode taken", 1'b1, 8'h71);
    do_ack(8'h71);
    do_eoi();
    check("R6 fresh level request", 32'(eoi_ntf_o), 32'h1);
    check("R6 fresh level vector", 32'(eoi_ntf_vec_o), 32'h71);
    do_req(8'h90, 1'b0, 3'b010);
    chk_pend("R6 reserved mode ignored", 1'b0, 8'h00);
    do_req(8'h91, 1'b0, 3'b100);
    chk_pend("R6 other mode ignored", 1'b0, 8'h00);
  endtask

  task automatic t_disable();
    do_reset();
    enable_i = 1'b0;
    do_req(8'h80, 1'b0, 3'b000);
    chk_pend("R7 nothing while off", 1'b0, 8'h00);
    enable_i = 1'b1;
    @(negedge clk);
    chk_pend("R7 request left no trace", 1'b0, 8'h00);
    do_req(8'h80, 1'b0, 3'b000);
    enable_i = 1'b0;
    @(negedge clk);
    chk_pend("R3 hidden while off", 1'b0, 8'h00);
    do_ack(8'h80);
    check("R7 ack works while off", 32'(ppr_o), 32'h80);
    enable_i = 1'b1;
    do_req(8'hC2, 1'b0, 3'b000);
    chk_pend("R3 offer after re-enable", 1'b1, 8'hC2);
  endtask

  task automatic t_same_cycle();
    do_reset();
    do_req(8'hA0, 1'b0, 3'b000);
    do_req_ack(8'hA0, 1'b0);
    check("R9 in service", 32'(ppr_o), 32'hA0);
    chk_pend("R9 blocked by own class", 1'b0, 8'h00);
    do_eoi();
    chk_pend("R9 requested again", 1'b1, 8'hA0);
    do_reset();
    do_req(8'hB0, 1'b1, 3'b000);
    do_req_ack(8'hB0, 1'b1);
    do_eoi();
    check("R9 level re-request kept", 32'(eoi_ntf_o), 32'h1);
    chk_pend("R9 level re-request pending", 1'b1, 8'hB0);
  endtask

  task automatic t_boundaries();
    do_reset();
    do_req(8'h1F, 1'b0, 3'b000);
    chk_pend("R1 word0 bit31", 1'b1, 8'h1F);
    do_req(8'h20, 1'b0, 3'b000);
    chk_pend("R1 word1 bit0 above word0", 1'b1, 8'h20);
    do_req(8'hFF, 1'b0, 3'b000);
    chk_pend("R1 top vector", 1'b1, 8'hFF);
    do_ack(8'hFF);
    chk_pend("R1 blocked under 0xFF", 1'b0, 8'h00);
    check("R2 ppr 0xF0", 32'(ppr_o), 32'hF0);
    do_eoi();
    chk_pend("R1 next highest", 1'b1, 8'h20);
    do_ack(8'h20);
    chk_pend("R1 remaining 0x1F", 1'b0, 8'h00);
    do_eoi();
    chk_pend("R1 0x1F offered", 1'b1, 8'h1F);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_class_gate();
    t_nested_eoi();
    t_level_drop();
    t_disable();
    t_same_cycle();
    t_boundaries();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..R9 actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule